// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block decides which transactions a bus bridge passes downstream. It holds two memory windows and two I/O windows. Each window has a base register and a limit register that host configuration software programs through a small register port. The port has a write strobe, a byte offset, write data, byte enables, and a combinational read-back path. Every register resets to zero. A window whose registers are all zero claims nothing, so a freshly reset bridge forwards no traffic.

Memory windows use 4 KB granularity over the full 32-bit space. I/O windows use doubleword granularity and are confined to the first 64 KB page of I/O space. Each transaction is presented as an address plus a type flag that selects memory or I/O. The transaction is compared against the windows of its own type. The outputs are one hit flag per window, an overall forward flag, and a prefetchable flag. The prefetchable flag is taken from external per-window control bits of the memory windows that match.

The block is purely a register bank and comparators. It has no state machine. A register write takes effect on the clock edge that samples it. Matching and read-back are combinational.

Top module: `bridge_window_decoder`

## Requirements
- R1: Memory base registers sit at offsets 1Ch and 24h, and memory limit registers at 20h and 28h, for windows 0 and 1. Bits 31..12 are writable and read back as written.
- R2: Bits 11..0 of every memory register always read as zero, and writing them has no effect.
- R3: After reset every register reads zero, apart from the select bit of R8, and no transaction is forwarded.
- R4: A window whose stored writable base and limit bits are all zero never hits. A nonzero value in either register enables the window.
- R5: A memory transaction (txn_is_io=0) hits memory window i when base[31:12] <= addr[31:12] <= limit[31:12]. The limit is therefore inclusive up to its 4 KB block end, and base above limit gives no hit.
- R6: prefetchable is 1 exactly when some memory window i hits and pf_ctl[i] is 1.
- R7: I/O base registers sit at offsets 2Ch and 34h, and I/O limit registers at 30h and 38h. Only bits 15..2 are writable. Bits 31..16 always read zero, and I/O limit bits 1..0 read zero.
- R8: I/O base bits 1..0 are read-only and return {0, io_low_sel}.
- R9: An I/O transaction (txn_is_io=1) hits I/O window j when addr[31:16]==0 and base[15:2] <= addr[15:2] <= limit[15:2]. The select bit of R8 does not count toward enabling the window.
- R10: A write changes only the bytes whose cfg_be bit is set. cfg_be[k] covers data bits 8k+7..8k.
- R11: Writes to any offset outside 1Ch..38h, or to one that is not doubleword aligned, change nothing, and reads of such offsets return zero.
- R12: Memory windows never hit an I/O transaction and I/O windows never hit a memory one. forward is the OR of all window hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_rdata | output | 32 | Read-back of the register at cfg_addr |
| pf_ctl | input | 2 | Prefetchable control, one bit per memory window |
| io_low_sel | input | 1 | Value returned in I/O base bit 0 |
| txn_addr | input | 32 | Transaction address |
| txn_is_io | input | 1 | 1 for an I/O transaction, 0 for memory |
| mem_hit | output | 2 | Hit flag per memory window |
| io_hit | output | 2 | Hit flag per I/O window |
| forward | output | 1 | Transaction is claimed for downstream |
| prefetchable | output | 1 | A matching memory window is prefetchable |

## Verification
The hardest situations to reach from the ports are the edge cases of window enabling and write masking. One is a window enabled only by its limit while its base stays zero, which then covers address zero. Another is an I/O window that reads back nonzero only because of the select bit, yet must stay disabled. A third is a partial byte-enable write that touches both a writable lane and a read-only lane. Directed writes build each of these cases, and probes are placed on the first and last address of each window and one step outside it. Random writes with random byte enables follow. Their transaction addresses are biased toward the current register values, so that boundary crossings happen often.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

    localparam int BWD_AW = 32;
    localparam int BWD_LANES = BWD_AW / 8;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_MEM_BASE,
        RK_MEM_LIMIT,
        RK_IO_BASE,
        RK_IO_LIMIT
    } reg_kind_e;

    function automatic logic [BWD_AW-1:0] lane_expand(input logic [BWD_LANES-1:0] be);
        logic [BWD_AW-1:0] m;
        for (int k = 0; k < BWD_LANES; k++) begin
            m[8*k +: 8] = {8{be[k]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/bwd_regfile.sv
module bwd_regfile
    import bwd_pkg::*;
#(
    parameter int N_MEM    = 2,
    parameter int N_IO     = 2,
    parameter int CFG_AW   = 8,
    parameter int REG_BASE = 'h1C,
    parameter int MEM_GRAN = 12,
    parameter int IO_GRAN  = 2,
    parameter int IO_SPACE = 16
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        cfg_wr,
    input  logic [CFG_AW-1:0]                           cfg_addr,
    input  logic [BWD_AW-1:0]                           cfg_wdata,
    input  logic [BWD_LANES-1:0]                        cfg_be,
    input  logic                                        io_low_sel,
    output logic [BWD_AW-1:0]                           cfg_rdata,
    output logic [N_MEM-1:0][BWD_AW-MEM_GRAN-1:0]       mem_base,
    output logic [N_MEM-1:0][BWD_AW-MEM_GRAN-1:0]       mem_limit,
    output logic [N_IO-1:0][IO_SPACE-IO_GRAN-1:0]       io_base,
    output logic [N_IO-1:0][IO_SPACE-IO_GRAN-1:0]       io_limit
);

    localparam int N_REG = 2 * (N_MEM + N_IO);
    localparam int IDX_W = $clog2(N_REG);
    localparam logic [CFG_AW:0] REG_END = CFG_AW'(REG_BASE) + CFG_AW'(4 * N_REG);
    localparam logic [BWD_AW-1:0] MEM_WMASK = ~((BWD_AW'(1) << MEM_GRAN) - 1);
    localparam logic [BWD_AW-1:0] IO_WMASK =
        ((BWD_AW'(1) << IO_SPACE) - 1) & ~((BWD_AW'(1) << IO_GRAN) - 1);

    logic [N_REG-1:0][BWD_AW-1:0] regs_q;
    logic [CFG_AW-1:0]            offs;
    logic [IDX_W-1:0]             reg_idx;
    logic                         sel_ok;
    reg_kind_e                    kind;

    always_comb begin
        offs    = cfg_addr - CFG_AW'(REG_BASE);
        reg_idx = offs[IDX_W+1:2];
        sel_ok  = ({1'b0, cfg_addr} >= (CFG_AW + 1)'(REG_BASE)) &&
                  ({1'b0, cfg_addr} < REG_END) && (cfg_addr[1:0] == 2'b00);
        if (!sel_ok) begin
            kind = RK_NONE;
        end else if (int'(reg_idx) < 2 * N_MEM) begin
            kind = reg_idx[0] ? RK_MEM_LIMIT : RK_MEM_BASE;
        end else begin
            kind = reg_idx[0] ? RK_IO_LIMIT : RK_IO_BASE;
        end
    end

    function automatic logic [BWD_AW-1:0] wmask_of(input int r);
        return (r < 2 * N_MEM) ? MEM_WMASK : IO_WMASK;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (cfg_wr && sel_ok) begin
            for (int r = 0; r < N_REG; r++) begin
                if (IDX_W'(r) == reg_idx) begin
                    regs_q[r] <= (regs_q[r] & ~(lane_expand(cfg_be) & wmask_of(r))) |
                                 (cfg_wdata & lane_expand(cfg_be) & wmask_of(r));
                end
            end
        end
    end

    always_comb begin
        unique case (kind)
            RK_NONE:      cfg_rdata = '0;
            RK_IO_BASE:   cfg_rdata = regs_q[reg_idx] | BWD_AW'(io_low_sel);
            default:      cfg_rdata = regs_q[reg_idx];
        endcase
    end

    for (genvar i = 0; i < N_MEM; i++) begin : g_mem_out
        assign mem_base[i]  = regs_q[2*i][BWD_AW-1:MEM_GRAN];
        assign mem_limit[i] = regs_q[2*i+1][BWD_AW-1:MEM_GRAN];
    end

    for (genvar j = 0; j < N_IO; j++) begin : g_io_out
        assign io_base[j]  = regs_q[2*N_MEM+2*j][IO_SPACE-1:IO_GRAN];
        assign io_limit[j] = regs_q[2*N_MEM+2*j+1][IO_SPACE-1:IO_GRAN];
    end

    // R2: memory register reads carry no low-order bits
    p_mem_low_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == RK_MEM_BASE || kind == RK_MEM_LIMIT) |-> (cfg_rdata[MEM_GRAN-1:0] == '0));

    // R7: I/O register reads stay inside the first page
    p_io_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == RK_IO_BASE || kind == RK_IO_LIMIT) |-> (cfg_rdata[BWD_AW-1:IO_SPACE] == '0));

    // R11: a write to an unmapped offset leaves the window outputs unchanged
    p_unmapped_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !sel_ok) |=> ($stable(mem_base) && $stable(mem_limit) &&
                                 $stable(io_base) && $stable(io_limit)));

endmodule

// File: rtl/bwd_window_cmp.sv
module bwd_window_cmp #(
    parameter int FW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          type_ok,
    input  logic          page_ok,
    input  logic [FW-1:0] addr_f,
    input  logic [FW-1:0] base_f,
    input  logic [FW-1:0] limit_f,
    output logic          hit
);

    logic enabled;
    logic in_range;

    always_comb begin
        enabled  = (base_f != '0) || (limit_f != '0);
        in_range = (addr_f >= base_f) && (addr_f <= limit_f);
        hit      = type_ok && page_ok && enabled && in_range;
    end

    // R4: an all-zero window is silent whatever the address
    p_disabled_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((base_f == '0) && (limit_f == '0)) |-> !hit);

endmodule

// File: rtl/bridge_window_decoder.sv
module bridge_window_decoder
    import bwd_pkg::*;
#(
    parameter int N_MEM    = 2,
    parameter int N_IO     = 2,
    parameter int CFG_AW   = 8,
    parameter int REG_BASE = 'h1C,
    parameter int MEM_GRAN = 12,
    parameter int IO_GRAN  = 2,
    parameter int IO_SPACE = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [BWD_AW-1:0]    cfg_wdata,
    input  logic [BWD_LANES-1:0] cfg_be,
    output logic [BWD_AW-1:0]    cfg_rdata,
    input  logic [N_MEM-1:0]     pf_ctl,
    input  logic                 io_low_sel,
    input  logic [BWD_AW-1:0]    txn_addr,
    input  logic                 txn_is_io,
    output logic [N_MEM-1:0]     mem_hit,
    output logic [N_IO-1:0]      io_hit,
    output logic                 forward,
    output logic                 prefetchable
);

    localparam int MEM_FW = BWD_AW - MEM_GRAN;
    localparam int IO_FW  = IO_SPACE - IO_GRAN;

    logic [N_MEM-1:0][MEM_FW-1:0] mem_base;
    logic [N_MEM-1:0][MEM_FW-1:0] mem_limit;
    logic [N_IO-1:0][IO_FW-1:0]   io_base;
    logic [N_IO-1:0][IO_FW-1:0]   io_limit;
    logic                         io_page_ok;

    bwd_regfile #(
        .N_MEM(N_MEM), .N_IO(N_IO), .CFG_AW(CFG_AW), .REG_BASE(REG_BASE),
        .MEM_GRAN(MEM_GRAN), .IO_GRAN(IO_GRAN), .IO_SPACE(IO_SPACE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .io_low_sel(io_low_sel),
        .cfg_rdata(cfg_rdata), .mem_base(mem_base), .mem_limit(mem_limit),
        .io_base(io_base), .io_limit(io_limit)
    );

    assign io_page_ok = (txn_addr[BWD_AW-1:IO_SPACE] == '0);

    for (genvar i = 0; i < N_MEM; i++) begin : g_mem_win
        bwd_window_cmp #(.FW(MEM_FW)) u_cmp (
            .clk(clk), .rst_n(rst_n), .type_ok(!txn_is_io), .page_ok(1'b1),
            .addr_f(txn_addr[BWD_AW-1:MEM_GRAN]), .base_f(mem_base[i]),
            .limit_f(mem_limit[i]), .hit(mem_hit[i])
        );
    end

    for (genvar j = 0; j < N_IO; j++) begin : g_io_win
        bwd_window_cmp #(.FW(IO_FW)) u_cmp (
            .clk(clk), .rst_n(rst_n), .type_ok(txn_is_io), .page_ok(io_page_ok),
            .addr_f(txn_addr[IO_SPACE-1:IO_GRAN]), .base_f(io_base[j]),
            .limit_f(io_limit[j]), .hit(io_hit[j])
        );
    end

    always_comb begin
        forward      = (|mem_hit) || (|io_hit);
        prefetchable = |(mem_hit & pf_ctl);
    end

    // R12: memory windows stay quiet for I/O traffic
    p_mem_type_r12: assert property (@(posedge clk) disable iff (!rst_n)
        txn_is_io |-> (mem_hit == '0));

    // R12: I/O windows stay quiet for memory traffic
    p_io_type_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !txn_is_io |-> (io_hit == '0));

    // R6: prefetch status only accompanies a memory match
    p_pf_needs_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        prefetchable |-> (forward && !txn_is_io));

    // R9: no I/O hit outside the first page
    p_io_page_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (io_hit != '0) |-> (txn_addr[BWD_AW-1:IO_SPACE] == '0));

endmodule

// File: tb/tb_bridge_window_decoder.sv
module tb_bridge_window_decoder;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_rdata;
    logic [1:0]  pf_ctl = '0;
    logic        io_low_sel = 1'b0;
    logic [31:0] txn_addr = '0;
    logic        txn_is_io = 1'b0;
    logic [1:0]  mem_hit;
    logic [1:0]  io_hit;
    logic        forward;
    logic        prefetchable;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    logic [31:0] mdl [8];

    bridge_window_decoder dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .cfg_rdata(cfg_rdata),
        .pf_ctl(pf_ctl), .io_low_sel(io_low_sel), .txn_addr(txn_addr),
        .txn_is_io(txn_is_io), .mem_hit(mem_hit), .io_hit(io_hit),
        .forward(forward), .prefetchable(prefetchable)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] wmask(input int idx);
        return (idx < 4) ? 32'hFFFF_F000 : 32'h0000_FFFC;
    endfunction

    function automatic logic [31:0] bemask(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        int idx;
        if (a < 8'h1C || a > 8'h38 || a[1:0] != 2'b00) return 32'h0;
        idx = (int'(a) - 'h1C) / 4;
        if (idx == 4 || idx == 6) return mdl[idx] | {31'h0, io_low_sel};
        return mdl[idx];
    endfunction

    function automatic logic [1:0] exp_mem(input logic [31:0] a, input logic io);
        logic [1:0] h;
        for (int i = 0; i < 2; i++) begin
            h[i] = !io && (mdl[2*i] != 0 || mdl[2*i+1] != 0) &&
                   a[31:12] >= mdl[2*i][31:12] && a[31:12] <= mdl[2*i+1][31:12];
        end
        return h;
    endfunction

    function automatic logic [1:0] exp_io(input logic [31:0] a, input logic io);
        logic [1:0] h;
        for (int j = 0; j < 2; j++) begin
            h[j] = io && a[31:16] == 16'h0 && (mdl[4+2*j] != 0 || mdl[5+2*j] != 0) &&
                   a[15:2] >= mdl[4+2*j][15:2] && a[15:2] <= mdl[5+2*j][15:2];
        end
        return h;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        int idx;
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = be;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (a >= 8'h1C && a <= 8'h38 && a[1:0] == 2'b00) begin
            idx = (int'(a) - 'h1C) / 4;
            mdl[idx] = (mdl[idx] & ~(bemask(be) & wmask(idx))) | (d & bemask(be) & wmask(idx));
        end
    endtask

    task automatic rd(input string tag, input logic [7:0] a);
        cfg_addr = a;
        #1;
        chk(tag, cfg_rdata, exp_read(a));
    endtask

    task automatic probe(input string tag, input logic [31:0] a, input logic io);
        logic [1:0] em;
        logic [1:0] ei;
        txn_addr = a; txn_is_io = io;
        #1;
        em = exp_mem(a, io);
        ei = exp_io(a, io);
        chk({tag, " mem_hit"}, {30'h0, mem_hit}, {30'h0, em});
        chk({tag, " io_hit"}, {30'h0, io_hit}, {30'h0, ei});
        chk({tag, " R12 forward"}, {31'h0, forward}, {31'h0, (|em) || (|ei)});
        chk({tag, " R6 prefetchable"}, {31'h0, prefetchable}, {31'h0, |(em & pf_ctl)});
    endtask

    task automatic probe_exp(input string tag, input logic [31:0] a, input logic io,
                             input logic [1:0] em, input logic [1:0] ei);
        txn_addr = a; txn_is_io = io;
        #1;
        chk({tag, " mem_hit"}, {30'h0, mem_hit}, {30'h0, em});
        chk({tag, " io_hit"}, {30'h0, io_hit}, {30'h0, ei});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] a;
        logic [31:0] t;
        int k;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: reset state
        for (int i = 0; i < 8; i++) rd("R3 reset read", 8'(8'h1C + 4*i));
        probe_exp("R3 reset mem 0", 32'h0, 1'b0, 2'b00, 2'b00);
        probe_exp("R3 reset io 0", 32'h0, 1'b1, 2'b00, 2'b00);
        probe("R3 reset mem high", 32'hFFFF_FFFF, 1'b0);

        // R8: select bit appears in I/O base, R9: it does not enable the window
        io_low_sel = 1'b1;
        rd("R8 io base0 sel", 8'h2C);
        rd("R8 io base1 sel", 8'h34);
        chk("R8 io base0 value", cfg_rdata, 32'h1);
        rd("R7 io limit0 low zero", 8'h30);
        probe_exp("R9 sel does not enable", 32'h0, 1'b1, 2'b00, 2'b00);

        // R1 / R2: memory window 0
        wr(8'h1C, 32'h1000_0FFF, 4'hF);
        wr(8'h20, 32'h1000_5ABC, 4'hF);
        rd("R1 mem base0", 8'h1C);
        cfg_addr = 8'h1C; #1;
        chk("R2 mem base0 low ignored", cfg_rdata, 32'h1000_0000);
        rd("R1 mem limit0", 8'h20);
        pf_ctl = 2'b01;
        probe_exp("R5 at base", 32'h1000_0000, 1'b0, 2'b01, 2'b00);
        probe_exp("R5 at limit end", 32'h1000_5FFF, 1'b0, 2'b01, 2'b00);
        probe_exp("R5 above limit", 32'h1000_6000, 1'b0, 2'b00, 2'b00);
        probe_exp("R5 below base", 32'h0FFF_FFFF, 1'b0, 2'b00, 2'b00);
        txn_addr = 32'h1000_2000; txn_is_io = 1'b0; #1;
        chk("R6 prefetchable set", {31'h0, prefetchable}, 32'h1);
        pf_ctl = 2'b10; #1;
        chk("R6 prefetchable clear", {31'h0, prefetchable}, 32'h0);
        probe_exp("R12 io type ignores mem win", 32'h1000_2000, 1'b1, 2'b00, 2'b00);

        // R4: enabled only by limit, base zero
        wr(8'h28, 32'h0000_1000, 4'hF);
        probe_exp("R4 limit only covers zero", 32'h0, 1'b0, 2'b10, 2'b00);
        probe_exp("R4 limit only top", 32'h0000_1FFF, 1'b0, 2'b10, 2'b00);
        wr(8'h28, 32'h0, 4'hF);
        probe_exp("R4 cleared window silent", 32'h0, 1'b0, 2'b00, 2'b00);

        // R10: partial byte enables
        wr(8'h24, 32'hFFFF_FFFF, 4'b0010);
        cfg_addr = 8'h24; #1;
        chk("R10 lane1 only", cfg_rdata, 32'h0000_F000);
        wr(8'h24, 32'hABCD_0000, 4'b1000);
        cfg_addr = 8'h24; #1;
        chk("R10 lane3 only", cfg_rdata, 32'hAB00_F000);
        wr(8'h24, 32'h0, 4'hF);

        // R7: I/O writable bits
        wr(8'h2C, 32'hFFFF_FFFF, 4'hF);
        cfg_addr = 8'h2C; #1;
        chk("R7 io base0 mask", cfg_rdata, 32'h0000_FFFD);
        wr(8'h30, 32'hFFFF_FFFF, 4'hF);
        cfg_addr = 8'h30; #1;
        chk("R7 io limit0 mask", cfg_rdata, 32'h0000_FFFC);

        // R9: I/O window 0 range
        wr(8'h2C, 32'h0000_0100, 4'hF);
        wr(8'h30, 32'h0000_01FC, 4'hF);
        probe_exp("R9 io at base", 32'h0000_0100, 1'b1, 2'b00, 2'b01);
        probe_exp("R9 io at limit end", 32'h0000_01FF, 1'b1, 2'b00, 2'b01);
        probe_exp("R9 io above limit", 32'h0000_0200, 1'b1, 2'b00, 2'b00);
        probe_exp("R9 io below base", 32'h0000_00FC, 1'b1, 2'b00, 2'b00);
        probe_exp("R9 io second page", 32'h0001_0100, 1'b1, 2'b00, 2'b00);
        probe_exp("R12 mem type ignores io win", 32'h0000_0100, 1'b0, 2'b00, 2'b00);

        // R11: unmapped and unaligned offsets
        wr(8'h18, 32'hFFFF_FFFF, 4'hF);
        wr(8'h3C, 32'hFFFF_FFFF, 4'hF);
        wr(8'h1D, 32'hFFFF_FFFF, 4'hF);
        rd("R11 read 18h", 8'h18);
        rd("R11 read 3Ch", 8'h3C);
        rd("R11 read 1Dh", 8'h1D);
        cfg_addr = 8'h1C; #1;
        chk("R11 base0 untouched", cfg_rdata, 32'h1000_0000);

        // Random phase
        for (int n = 0; n < 400; n++) begin
            k = int'($urandom % 9);
            a = (k == 8) ? 8'($urandom) : 8'(8'h1C + 4*k);
            wr(a, $urandom, 4'($urandom));
            pf_ctl = 2'($urandom);
            io_low_sel = 1'($urandom);
            rd("R1 R7 R10 random read", a);
            for (int m = 0; m < 4; m++) begin
                k = int'($urandom % 4);
                case (k)
                    0: t = $urandom;
                    1: t = mdl[$urandom % 4] + 32'($urandom % 32'h3000) - 32'h1000;
                    2: t = {16'h0, 16'($urandom)};
                    default: t = mdl[4 + $urandom % 4] + 32'($urandom % 16) - 32'h8;
                endcase
                probe("R5 R9 random", t, (k >= 2) ? ($urandom % 8 != 0) : ($urandom % 8 == 0));
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule